// File: doc/BRIEF.md
# Fused Wide-Vector Port Dispatcher

This block is the issue stage that sits between a micro-op scheduler and three execution ports. Two ready micro-ops arrive per cycle in age order (slot 0 is the older), each tagged as integer, 256-bit vector or 512-bit vector work. Ports 0 and 1 each carry an integer ALU and a 256-bit vector unit. Port 5 carries a dedicated 512-bit vector unit when the `HAS_WIDE5` parameter is 1; otherwise it is absent.

A 512-bit micro-op is always dispatched through port 0. It also claims the vector unit of port 1, because the two 256-bit halves are fused to form the wide datapath. The integer ALUs on both ports stay free for unrelated integer work in that same cycle. Grants return to the scheduler combinationally in the cycle the micro-ops are presented. A micro-op that is not granted stays in its slot and is presented again. Granted micro-ops appear on the registered per-port issue outputs one clock later.

Each unit is fully pipelined with a one-cycle occupancy. Resource claims therefore live for a single cycle, and a unit can take new work on every clock.

Top module: `vec_port_dispatch`

## Requirements
- R1: While reset is asserted (`rstN` low, asynchronous), every issue valid, the wide flag, the fused flag and every issue tag are 0.
- R2: Integer micro-ops take the port 0 ALU first and the port 1 ALU second, in age order. When a fused 512-bit micro-op is granted in the same cycle, the integer micro-op goes to the port 1 ALU instead.
- R3: Vector-256 micro-ops take the port 0 vector unit first and the port 1 vector unit second, in age order.
- R4: A granted 512-bit micro-op on the fused pair issues on port 0 with `p0VecValid`=1 and `p0VecWide`=1. In the same cycle `p1VecFused`=1 and `p1VecValid`=0.
- R5: An integer micro-op is granted and issued in the same cycle as a fused 512-bit micro-op, whichever slot holds either.
- R6: A vector-256 micro-op is not granted in a cycle in which the fused pair is granted to a 512-bit micro-op.
- R7: With `HAS_WIDE5`=1 and two 512-bit micro-ops ready, the older goes to the fused pair and the younger to port 5. With `HAS_WIDE5`=0 the younger is not granted, and `p5WideValid` is always 0.
- R8: A 512-bit micro-op in slot 1 behind a vector-256 micro-op in slot 0 goes to port 5 when `HAS_WIDE5`=1 and is not granted otherwise. Port 5 is used only when the port 0 vector unit is already taken that cycle.
- R9: Slot 1 is never granted while slot 0 holds a valid micro-op that is not granted.
- R10: Kind code 3 is reserved. A micro-op carrying it is never granted and issues nothing. Kind codes: 0 integer, 1 vector-256, 2 vector-512.
- R11: Grants are valid in the cycle of presentation. The issue outputs reflect those grants after the next rising clock edge, each for one cycle. The number of issue valids then equals the number of grants, and back-to-back cycles may issue to the same units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid0 | input | 1 | Slot 0 (older) micro-op ready |
| inKind0 | input | 2 | Slot 0 kind: 0 int, 1 vec256, 2 vec512, 3 reserved |
| inTag0 | input | TAG_W | Slot 0 micro-op tag |
| inValid1 | input | 1 | Slot 1 (younger) micro-op ready |
| inKind1 | input | 2 | Slot 1 kind |
| inTag1 | input | TAG_W | Slot 1 micro-op tag |
| grant0 | output | 1 | Slot 0 accepted this cycle |
| grant1 | output | 1 | Slot 1 accepted this cycle |
| p0IntValid | output | 1 | Port 0 ALU issue |
| p0IntTag | output | TAG_W | Port 0 ALU tag |
| p0VecValid | output | 1 | Port 0 vector issue |
| p0VecWide | output | 1 | Port 0 vector issue is a fused 512-bit op |
| p0VecTag | output | TAG_W | Port 0 vector tag |
| p1IntValid | output | 1 | Port 1 ALU issue |
| p1IntTag | output | TAG_W | Port 1 ALU tag |
| p1VecValid | output | 1 | Port 1 vector issue of its own 256-bit op |
| p1VecFused | output | 1 | Port 1 vector unit lent to the fused op |
| p1VecTag | output | TAG_W | Port 1 vector tag |
| p5WideValid | output | 1 | Port 5 wide unit issue |
| p5WideTag | output | TAG_W | Port 5 tag |

## Verification
A wrong claim in the grant logic shows up in two places. It appears on `grant0`/`grant1` in the same cycle, and on the per-port valids one edge later. Examples are a fused pair that forgets port 1, or a port 5 that is used without being built. The effect is a port 1 valid asserted next to the fused flag, a lost younger grant, or an issue count that differs from the grant count. A routing fault in the tag multiplexing is visible only on the tag outputs, one cycle after the grant. The bench therefore checks each pattern on both configurations in the grant cycle and in the following cycle, and checks tags on the cases where one slot could be steered to either of two units.

// File: rtl/vecdisp_pkg.sv
package vecdisp_pkg;

  typedef enum logic [1:0] {
    KIND_INT  = 2'd0,
    KIND_V256 = 2'd1,
    KIND_V512 = 2'd2,
    KIND_RSV  = 2'd3
  } uop_kind_e;

  // Per-cycle strobes from grant control to the issue datapath.
  // A *Sel bit names the source slot (0 older, 1 younger).
  typedef struct packed {
    logic p0IntEn;
    logic p0IntSel;
    logic p1IntEn;
    logic p1IntSel;
    logic p0VecEn;
    logic p0VecSel;
    logic pairWide;   // port 0 vector op is 512-bit and owns port 1 vector half
    logic p1VecEn;
    logic p1VecSel;
    logic p5En;
    logic p5Sel;
  } issue_strobe_t;

endpackage

// File: rtl/vec_port_grant_ctrl.sv
module vec_port_grant_ctrl
  import vecdisp_pkg::*;
#(
  parameter bit HAS_WIDE5 = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid0,
  input  logic [1:0]    inKind0,
  input  logic          inValid1,
  input  logic [1:0]    inKind1,
  output logic          grant0,
  output logic          grant1,
  output issue_strobe_t strobe
);

  logic intPending0;
  logic intPending1;
  logic slot1Allowed;

  always_comb begin
    strobe       = '0;
    grant0       = 1'b0;
    grant1       = 1'b0;
    intPending0  = 1'b0;
    intPending1  = 1'b0;

    // Older slot: always finds its resource when its kind is defined.
    if (inValid0) begin
      case (inKind0)
        KIND_V512: begin
          strobe.p0VecEn  = 1'b1;
          strobe.p0VecSel = 1'b0;
          strobe.pairWide = 1'b1;
          grant0          = 1'b1;
        end
        KIND_V256: begin
          strobe.p0VecEn  = 1'b1;
          strobe.p0VecSel = 1'b0;
          grant0          = 1'b1;
        end
        KIND_INT: begin
          grant0      = 1'b1;
          intPending0 = 1'b1;
        end
        default: ;
      endcase
    end

    // Younger slot may only go when the older one did not stall.
    slot1Allowed = !inValid0 || grant0;

    if (inValid1 && slot1Allowed) begin
      case (inKind1)
        KIND_V512: begin
          if (!strobe.p0VecEn) begin
            strobe.p0VecEn  = 1'b1;
            strobe.p0VecSel = 1'b1;
            strobe.pairWide = 1'b1;
            grant1          = 1'b1;
          end else if (HAS_WIDE5) begin
            strobe.p5En  = 1'b1;
            strobe.p5Sel = 1'b1;
            grant1       = 1'b1;
          end
        end
        KIND_V256: begin
          if (!strobe.p0VecEn) begin
            strobe.p0VecEn  = 1'b1;
            strobe.p0VecSel = 1'b1;
            grant1          = 1'b1;
          end else if (!strobe.pairWide) begin
            strobe.p1VecEn  = 1'b1;
            strobe.p1VecSel = 1'b1;
            grant1          = 1'b1;
          end
        end
        KIND_INT: begin
          grant1      = 1'b1;
          intPending1 = 1'b1;
        end
        default: ;
      endcase
    end

    // Integer ALU placement, after the vector claims are known.
    if (intPending0) begin
      if (strobe.pairWide) begin
        strobe.p1IntEn  = 1'b1;
        strobe.p1IntSel = 1'b0;
      end else begin
        strobe.p0IntEn  = 1'b1;
        strobe.p0IntSel = 1'b0;
      end
    end
    if (intPending1) begin
      if (strobe.pairWide || strobe.p0IntEn) begin
        strobe.p1IntEn  = 1'b1;
        strobe.p1IntSel = 1'b1;
      end else begin
        strobe.p0IntEn  = 1'b1;
        strobe.p0IntSel = 1'b1;
      end
    end
  end

  // R9: age order kept at the grant interface
  a_r9_in_order: assert property (@(posedge clk) disable iff (!rstN)
    (inValid0 && !grant0) |-> !grant1);

  // R10: reserved kind never granted
  a_r10_rsv_slot0: assert property (@(posedge clk) disable iff (!rstN)
    (inValid0 && inKind0 == KIND_RSV) |-> !grant0);
  a_r10_rsv_slot1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid1 && inKind1 == KIND_RSV) |-> !grant1);

  // R8: port 5 only taken when the port 0 vector unit is already claimed
  a_r8_p5_overflow_only: assert property (@(posedge clk) disable iff (!rstN)
    strobe.p5En |-> strobe.p0VecEn);

  // R6: a 256-bit op never lands on port 1 while the pair is fused
  a_r6_no_split_pair: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pairWide |-> !strobe.p1VecEn);

endmodule

// File: rtl/vec_port_issue_dp.sv
module vec_port_issue_dp
  import vecdisp_pkg::*;
#(
  parameter int TAG_W     = 6,
  parameter bit HAS_WIDE5 = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  issue_strobe_t    strobe,
  input  logic [TAG_W-1:0] inTag0,
  input  logic [TAG_W-1:0] inTag1,
  output logic             p0IntValid,
  output logic [TAG_W-1:0] p0IntTag,
  output logic             p0VecValid,
  output logic             p0VecWide,
  output logic [TAG_W-1:0] p0VecTag,
  output logic             p1IntValid,
  output logic [TAG_W-1:0] p1IntTag,
  output logic             p1VecValid,
  output logic             p1VecFused,
  output logic [TAG_W-1:0] p1VecTag,
  output logic             p5WideValid,
  output logic [TAG_W-1:0] p5WideTag
);

  localparam logic [TAG_W-1:0] TAG_IDLE = '0;

  function automatic logic [TAG_W-1:0] pickTag(input logic en, input logic sel,
                                              input logic [TAG_W-1:0] t0,
                                              input logic [TAG_W-1:0] t1);
    if (!en) return TAG_IDLE;
    return sel ? t1 : t0;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p0IntValid <= 1'b0;
      p0IntTag   <= TAG_IDLE;
      p0VecValid <= 1'b0;
      p0VecWide  <= 1'b0;
      p0VecTag   <= TAG_IDLE;
      p1IntValid <= 1'b0;
      p1IntTag   <= TAG_IDLE;
      p1VecValid <= 1'b0;
      p1VecFused <= 1'b0;
      p1VecTag   <= TAG_IDLE;
    end else begin
      p0IntValid <= strobe.p0IntEn;
      p0IntTag   <= pickTag(strobe.p0IntEn, strobe.p0IntSel, inTag0, inTag1);
      p0VecValid <= strobe.p0VecEn;
      p0VecWide  <= strobe.p0VecEn && strobe.pairWide;
      p0VecTag   <= pickTag(strobe.p0VecEn, strobe.p0VecSel, inTag0, inTag1);
      p1IntValid <= strobe.p1IntEn;
      p1IntTag   <= pickTag(strobe.p1IntEn, strobe.p1IntSel, inTag0, inTag1);
      p1VecValid <= strobe.p1VecEn;
      p1VecFused <= strobe.pairWide;
      p1VecTag   <= pickTag(strobe.p1VecEn, strobe.p1VecSel, inTag0, inTag1);
    end
  end

  generate
    if (HAS_WIDE5) begin : gWide5
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          p5WideValid <= 1'b0;
          p5WideTag   <= TAG_IDLE;
        end else begin
          p5WideValid <= strobe.p5En;
          p5WideTag   <= pickTag(strobe.p5En, strobe.p5Sel, inTag0, inTag1);
        end
      end
    end else begin : gNoWide5
      assign p5WideValid = 1'b0;
      assign p5WideTag   = TAG_IDLE;
    end
  endgenerate

  // R4: fused flag on port 1 tracks the wide op on port 0
  a_r4_pair_together: assert property (@(posedge clk) disable iff (!rstN)
    p0VecWide |-> (p0VecValid && p1VecFused));

  // R6: port 1 vector half never carries its own op while lent out
  a_r6_fused_excl: assert property (@(posedge clk) disable iff (!rstN)
    p1VecFused |-> !p1VecValid);

endmodule

// File: rtl/vec_port_dispatch.sv
module vec_port_dispatch
  import vecdisp_pkg::*;
#(
  parameter int TAG_W     = 6,
  parameter bit HAS_WIDE5 = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid0,
  input  logic [1:0]       inKind0,
  input  logic [TAG_W-1:0] inTag0,
  input  logic             inValid1,
  input  logic [1:0]       inKind1,
  input  logic [TAG_W-1:0] inTag1,
  output logic             grant0,
  output logic             grant1,
  output logic             p0IntValid,
  output logic [TAG_W-1:0] p0IntTag,
  output logic             p0VecValid,
  output logic             p0VecWide,
  output logic [TAG_W-1:0] p0VecTag,
  output logic             p1IntValid,
  output logic [TAG_W-1:0] p1IntTag,
  output logic             p1VecValid,
  output logic             p1VecFused,
  output logic [TAG_W-1:0] p1VecTag,
  output logic             p5WideValid,
  output logic [TAG_W-1:0] p5WideTag
);

  issue_strobe_t strobe;

  vec_port_grant_ctrl #(.HAS_WIDE5(HAS_WIDE5)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid0 (inValid0),
    .inKind0  (inKind0),
    .inValid1 (inValid1),
    .inKind1  (inKind1),
    .grant0   (grant0),
    .grant1   (grant1),
    .strobe   (strobe)
  );

  vec_port_issue_dp #(.TAG_W(TAG_W), .HAS_WIDE5(HAS_WIDE5)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inTag0      (inTag0),
    .inTag1      (inTag1),
    .p0IntValid  (p0IntValid),
    .p0IntTag    (p0IntTag),
    .p0VecValid  (p0VecValid),
    .p0VecWide   (p0VecWide),
    .p0VecTag    (p0VecTag),
    .p1IntValid  (p1IntValid),
    .p1IntTag    (p1IntTag),
    .p1VecValid  (p1VecValid),
    .p1VecFused  (p1VecFused),
    .p1VecTag    (p1VecTag),
    .p5WideValid (p5WideValid),
    .p5WideTag   (p5WideTag)
  );

  // R11: every grant becomes exactly one issue valid one edge later
  a_r11_grant_to_issue: assert property (@(posedge clk) disable iff (!rstN)
    (grant0 || grant1) |=> ($countones({p0IntValid, p1IntValid, p0VecValid,
                                        p1VecValid, p5WideValid})
                            == $countones($past({grant0, grant1}))));

  // R7: without the port 5 unit nothing ever issues there
  a_r7_no_p5_when_absent: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_WIDE5 |-> !p5WideValid);

endmodule

// File: tb/vec_port_dispatch_test.sv
module vec_port_dispatch_test;

  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic             inValid0, inValid1;
  logic [1:0]       inKind0, inKind1;
  logic [TAG_W-1:0] inTag0, inTag1;

  logic g0H, g1H, g0L, g1L;
  logic p0IH, p0VH, p0WH, p1IH, p1VH, p1FH, p5H;
  logic p0IL, p0VL, p0WL, p1IL, p1VL, p1FL, p5L;
  logic [TAG_W-1:0] t0IH, t0VH, t1IH, t1VH, t5H;
  logic [TAG_W-1:0] t0IL, t0VL, t1IL, t1VL, t5L;

  vec_port_dispatch #(.TAG_W(TAG_W), .HAS_WIDE5(1'b1)) uut (
    .clk(clk), .rstN(rstN),
    .inValid0(inValid0), .inKind0(inKind0), .inTag0(inTag0),
    .inValid1(inValid1), .inKind1(inKind1), .inTag1(inTag1),
    .grant0(g0H), .grant1(g1H),
    .p0IntValid(p0IH), .p0IntTag(t0IH),
    .p0VecValid(p0VH), .p0VecWide(p0WH), .p0VecTag(t0VH),
    .p1IntValid(p1IH), .p1IntTag(t1IH),
    .p1VecValid(p1VH), .p1VecFused(p1FH), .p1VecTag(t1VH),
    .p5WideValid(p5H), .p5WideTag(t5H));

  vec_port_dispatch #(.TAG_W(TAG_W), .HAS_WIDE5(1'b0)) uutLow (
    .clk(clk), .rstN(rstN),
    .inValid0(inValid0), .inKind0(inKind0), .inTag0(inTag0),
    .inValid1(inValid1), .inKind1(inKind1), .inTag1(inTag1),
    .grant0(g0L), .grant1(g1L),
    .p0IntValid(p0IL), .p0IntTag(t0IL),
    .p0VecValid(p0VL), .p0VecWide(p0WL), .p0VecTag(t0VL),
    .p1IntValid(p1IL), .p1IntTag(t1IL),
    .p1VecValid(p1VL), .p1VecFused(p1FL), .p1VecTag(t1VL),
    .p5WideValid(p5L), .p5WideTag(t5L));

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // hi = {g0,g1,p0Int,p1Int,p0Vec,p0Wide,p1Vec,p1Fused,p5}  (HAS_WIDE5=1)
  // lo = {g0,g1,p0Int,p1Int,p0Vec,p0Wide,p1Vec,p1Fused}     (HAS_WIDE5=0)
  typedef struct packed {
    logic       v0;
    logic [1:0] k0;
    logic       v1;
    logic [1:0] k1;
    logic [8:0] hi;
    logic [7:0] lo;
  } vrow_t;

  localparam int NV = 13;
  localparam vrow_t VEC [NV] = '{
    '{1'b1, 2'd0, 1'b0, 2'd0, 9'b1_0_1_0_0_0_0_0_0, 8'b1_0_1_0_0_0_0_0}, // int alone
    '{1'b1, 2'd0, 1'b1, 2'd0, 9'b1_1_1_1_0_0_0_0_0, 8'b1_1_1_1_0_0_0_0}, // int,int
    '{1'b1, 2'd1, 1'b1, 2'd1, 9'b1_1_0_0_1_0_1_0_0, 8'b1_1_0_0_1_0_1_0}, // v256,v256
    '{1'b1, 2'd2, 1'b1, 2'd0, 9'b1_1_0_1_1_1_0_1_0, 8'b1_1_0_1_1_1_0_1}, // v512,int
    '{1'b1, 2'd0, 1'b1, 2'd2, 9'b1_1_0_1_1_1_0_1_0, 8'b1_1_0_1_1_1_0_1}, // int,v512
    '{1'b1, 2'd2, 1'b1, 2'd1, 9'b1_0_0_0_1_1_0_1_0, 8'b1_0_0_0_1_1_0_1}, // v512,v256
    '{1'b1, 2'd2, 1'b1, 2'd2, 9'b1_1_0_0_1_1_0_1_1, 8'b1_0_0_0_1_1_0_1}, // v512,v512
    '{1'b1, 2'd1, 1'b1, 2'd2, 9'b1_1_0_0_1_0_0_0_1, 8'b1_0_0_0_1_0_0_0}, // v256,v512
    '{1'b1, 2'd0, 1'b1, 2'd1, 9'b1_1_1_0_1_0_0_0_0, 8'b1_1_1_0_1_0_0_0}, // int,v256
    '{1'b1, 2'd3, 1'b1, 2'd0, 9'b0_0_0_0_0_0_0_0_0, 8'b0_0_0_0_0_0_0_0}, // rsv,int
    '{1'b0, 2'd0, 1'b1, 2'd2, 9'b0_1_0_0_1_1_0_1_0, 8'b0_1_0_0_1_1_0_1}, // -,v512
    '{1'b1, 2'd1, 1'b1, 2'd0, 9'b1_1_1_0_1_0_0_0_0, 8'b1_1_1_0_1_0_0_0}, // v256,int
    '{1'b0, 2'd0, 1'b0, 2'd0, 9'b0_0_0_0_0_0_0_0_0, 8'b0_0_0_0_0_0_0_0}  // idle
  };

  task automatic drive(input logic v0, input logic [1:0] k0, input logic [TAG_W-1:0] t0,
                       input logic v1, input logic [1:0] k1, input logic [TAG_W-1:0] t1);
    @(negedge clk);
    inValid0 = v0; inKind0 = k0; inTag0 = t0;
    inValid1 = v1; inKind1 = k1; inTag1 = t1;
    #1;
  endtask

  initial begin
    inValid0 = 0; inValid1 = 0; inKind0 = 0; inKind1 = 0; inTag0 = 0; inTag1 = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset valids hi", {p0IH, p0VH, p0WH, p1IH, p1VH, p1FH, p5H}, 0);
    chk("R1 reset tags hi", {t0IH, t0VH, t1IH, t1VH, t5H}, 0);
    chk("R1 reset valids lo", {p0IL, p0VL, p0WL, p1IL, p1VL, p1FL, p5L}, 0);
    @(negedge clk); rstN = 1'b1;

    // Table walk: R2..R11
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].v0, VEC[i].k0, TAG_W'(2*i+1), VEC[i].v1, VEC[i].k1, TAG_W'(2*i+2));
      chk($sformatf("R11 grants hi row %0d", i), {g0H, g1H}, VEC[i].hi[8:7]);
      chk($sformatf("R7 R8 R9 R10 grants lo row %0d", i), {g0L, g1L}, VEC[i].lo[7:6]);
      @(posedge clk); #1;
      chk($sformatf("R2 R3 R4 R5 R6 issue hi row %0d", i),
          {p0IH, p1IH, p0VH, p0WH, p1VH, p1FH, p5H}, VEC[i].hi[6:0]);
      chk($sformatf("R7 R8 issue lo row %0d", i),
          {p0IL, p1IL, p0VL, p0WL, p1VL, p1FL, p5L}, {VEC[i].lo[5:0], 1'b0});
    end

    // R2 tags: int,int -> older on port 0 ALU
    drive(1, 2'd0, 6'h11, 1, 2'd0, 6'h22);
    @(posedge clk); #1;
    chk("R2 p0 ALU tag", t0IH, 6'h11);
    chk("R2 p1 ALU tag", t1IH, 6'h22);

    // R3 tags: v256,v256
    drive(1, 2'd1, 6'h13, 1, 2'd1, 6'h24);
    @(posedge clk); #1;
    chk("R3 p0 vec tag", t0VH, 6'h13);
    chk("R3 p1 vec tag", t1VH, 6'h24);

    // R5 tags: int older, v512 younger -> int on port 1 ALU, wide on port 0
    drive(1, 2'd0, 6'h05, 1, 2'd2, 6'h06);
    @(posedge clk); #1;
    chk("R5 p1 ALU tag", t1IH, 6'h05);
    chk("R4 p0 wide tag", t0VH, 6'h06);
    chk("R4 p1 vec tag idle", t1VH, 6'h00);

    // R7 tags: v512,v512 -> older on pair, younger on port 5
    drive(1, 2'd2, 6'h31, 1, 2'd2, 6'h32);
    @(posedge clk); #1;
    chk("R7 pair tag", t0VH, 6'h31);
    chk("R7 p5 tag", t5H, 6'h32);
    chk("R7 lo p5 tag", t5L, 6'h00);

    // R11: second back-to-back wide pair issues again next cycle
    drive(1, 2'd2, 6'h33, 1, 2'd2, 6'h34);
    @(posedge clk); #1;
    chk("R11 back-to-back pair", {p0WH, p5H}, 2'b11);
    chk("R11 back-to-back p5 tag", t5H, 6'h34);

    // R8 tags: v256 then v512 -> v256 on p0, v512 on p5
    drive(1, 2'd1, 6'h07, 1, 2'd2, 6'h08);
    @(posedge clk); #1;
    chk("R8 p0 vec tag", t0VH, 6'h07);
    chk("R8 p5 tag", t5H, 6'h08);

    // R1: asynchronous reset while outputs are busy
    drive(1, 2'd2, 6'h3a, 1, 2'd2, 6'h3b);
    @(posedge clk); #1;
    chk("R1 pre-reset busy", {p0WH, p5H}, 2'b11);
    @(negedge clk); rstN = 1'b0; #1;
    chk("R1 async clear hi", {p0IH, p0VH, p0WH, p1IH, p1VH, p1FH, p5H}, 0);
    chk("R1 async clear tags", {t0VH, t5H}, 0);
    chk("R1 async clear lo", {p0VL, p0WL, p1FL}, 0);
    @(negedge clk); rstN = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule